// File: doc/BRIEF.md
# Program Counter and Fetch Sequencer

This block owns the 12-bit program address of a byte-wide instruction ROM. Each cycle it drives the ROM address. It offers the returned byte to the instruction decoder as a stream, and it moves to a new address when the decoder accepts that byte. The decoder sends one operation code with each accepted byte. The code selects one of six actions: step to the next byte, jump, call, one-byte short call into the zero page, return, or table read. A call of either kind sends the following address out on a push strobe so that the return stack can save it.

The interrupt controller can request entry at any fetch cycle. The fetch sequencer then withholds the current byte, pushes its address and jumps to the supplied vector. A table read borrows the ROM bus for one cycle to fetch an 8-bit constant from a given address. It then offers that constant on a second stream and resumes fetching at the address that follows the table instruction.

The ROM is external and combinational: `rom_rdata` must reflect `rom_addr` in the same cycle. Back-pressure works as follows. The instruction stream transfers on a cycle where `ins_valid` and `ins_ready` are both high. While `ins_ready` is low, the address and the offered byte stay where they are. The table stream holds `tbl_valid` and `tbl_data` until `tbl_ready` is seen high. The push strobe and the control inputs are plain signals with no handshake.

Top module: `pcfs_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the program address is 000h, `rom_addr` is 000h, `ins_valid` is high (unless an interrupt is requested) and `tbl_valid` is low.
- R2: An accepted byte with `op_sel` = 0 (step), or with one of the unused codes 6 or 7, advances the address by one. FFFh wraps to 000h.
- R3: In a fetch cycle with no interrupt request and `ins_ready` low, the address, `ins_addr` and `ins_data` stay the same into the next cycle. No push is issued.
- R4: An accepted byte with `op_sel` = 1 (jump) loads `br_target` into the address.
- R5: An accepted byte with `op_sel` = 2 (call) loads `br_target`. In the same cycle it raises `push_valid` with `push_addr` equal to the accepted address plus one, modulo 4096.
- R6: An accepted byte with `op_sel` = 3 (short call) loads the address with its own low six bits times eight. The result is a slot in 000h..1F8h with bits [2:0] zero. It also pushes the accepted address plus one.
- R7: An accepted byte with `op_sel` = 4 (return) loads `ret_addr` and issues no push.
- R8: An accepted byte with `op_sel` = 5 (table) puts `tbl_addr` on `rom_addr` in the next cycle with `ins_valid` low. In the cycle after that it offers the ROM byte read there on `tbl_data`. Fetching then resumes at the table instruction's address plus one.
- R9: While `tbl_valid` is high and `tbl_ready` is low, `tbl_valid` and `tbl_data` hold. The handshake cycle returns the block to fetching in the next cycle.
- R10: An `irq_req` in a fetch cycle has the following effects in that cycle. It forces `ins_valid` low and raises `push_valid` with `push_addr` equal to the current address. `op_sel` and `ins_ready` are ignored. The address becomes `irq_vec` in the next cycle.
- R11: An `irq_req` during the two table cycles has no effect. There is no push, the table constant is still delivered, and fetching resumes at the saved address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rom_addr | output | 12 | ROM address |
| rom_rdata | input | 8 | ROM byte at `rom_addr`, same cycle |
| ins_valid | output | 1 | Instruction byte offered |
| ins_ready | input | 1 | Decoder accepts the offered byte |
| ins_data | output | 8 | Offered instruction byte |
| ins_addr | output | 12 | Address of the offered byte |
| op_sel | input | 3 | Operation for the accepted byte: 0 step, 1 jump, 2 call, 3 short call, 4 return, 5 table |
| br_target | input | 12 | Jump and call destination |
| ret_addr | input | 12 | Address popped from the return stack |
| irq_req | input | 1 | Interrupt entry request |
| irq_vec | input | 12 | Interrupt entry address |
| tbl_addr | input | 12 | Table constant address |
| push_valid | output | 1 | Return address to be pushed this cycle |
| push_addr | output | 12 | Return address value |
| tbl_valid | output | 1 | Table constant offered |
| tbl_ready | input | 1 | Consumer accepts the table constant |
| tbl_data | output | 8 | Table constant |

## Verification
An interrupt request and a decoded control operation can meet in one fetch cycle, and both want to load the address and to drive the push port. The bench provokes this by raising `irq_req` together with call, short-call, jump and table codes while `ins_ready` is high. It also raises the request in the middle of a table read. A behavioural model runs on every clock and judges that the interrupt wins in fetch: no byte is offered, the current address is pushed and the vector is loaded. The same model judges that a request during the table cycles leaves the constant, the push port and the resumed address untouched.

// File: rtl/pcfs_pkg.sv
package pcfs_pkg;

  typedef enum logic [2:0] {
    OP_STEP  = 3'd0,
    OP_JUMP  = 3'd1,
    OP_CALL  = 3'd2,
    OP_SCALL = 3'd3,
    OP_RET   = 3'd4,
    OP_TABLE = 3'd5
  } pc_op_e;

  typedef enum logic [1:0] {
    ST_FETCH   = 2'd0,
    ST_TBL_RD  = 2'd1,
    ST_TBL_OUT = 2'd2
  } fetch_st_e;

endpackage

// File: rtl/pcfs_next.sv
module pcfs_next
  import pcfs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int SLOT_SHIFT = 3,
  parameter int SLOT_W     = 6
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] opcode,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic [ADDR_W-1:0] nxt_pc,
  output logic [ADDR_W-1:0] pc_inc,
  output logic              push_req,
  output logic              tbl_go
);
  localparam int PAD_W = ADDR_W - SLOT_W - SLOT_SHIFT;

  logic [ADDR_W-1:0] slot_target;

  assign pc_inc = pc + ADDR_W'(1);

  generate
    if (PAD_W > 0) begin : g_pad
      assign slot_target = {{PAD_W{1'b0}}, opcode[SLOT_W-1:0], {SLOT_SHIFT{1'b0}}};
    end else begin : g_nopad
      assign slot_target = {opcode[SLOT_W-1:0], {SLOT_SHIFT{1'b0}}};
    end
  endgenerate

  always_comb begin
    nxt_pc   = pc_inc;
    push_req = 1'b0;
    tbl_go   = 1'b0;
    case (op)
      OP_JUMP:  nxt_pc = br_target;
      OP_CALL:  begin nxt_pc = br_target;   push_req = 1'b1; end
      OP_SCALL: begin nxt_pc = slot_target; push_req = 1'b1; end
      OP_RET:   nxt_pc = ret_addr;
      OP_TABLE: tbl_go = 1'b1;
      default:  nxt_pc = pc_inc;
    endcase
  end

endmodule

// File: rtl/pcfs_table.sv
module pcfs_table #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rd_phase,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (capture)  addr_q <= addr_in;
      if (rd_phase) data_q <= rom_rdata;
    end
  end

endmodule

// File: rtl/pcfs_top.sv
module pcfs_top
  import pcfs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int SLOT_SHIFT = 3,
  parameter int SLOT_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              ins_valid,
  input  logic              ins_ready,
  output logic [DATA_W-1:0] ins_data,
  output logic [ADDR_W-1:0] ins_addr,
  input  logic [2:0]        op_sel,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic              irq_req,
  input  logic [ADDR_W-1:0] irq_vec,
  input  logic [ADDR_W-1:0] tbl_addr,
  output logic              push_valid,
  output logic [ADDR_W-1:0] push_addr,
  output logic              tbl_valid,
  input  logic              tbl_ready,
  output logic [DATA_W-1:0] tbl_data
);
  localparam int ZP_LIMIT = (1 << (SLOT_W + SLOT_SHIFT));

  fetch_st_e         state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] nxt_pc, pc_inc, tbl_addr_q;
  logic              push_req, tbl_go, in_fetch, step;

  assign in_fetch = (state_q == ST_FETCH);
  assign step     = in_fetch && !irq_req && ins_ready;

  pcfs_next #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_SHIFT(SLOT_SHIFT), .SLOT_W(SLOT_W)
  ) u_next (
    .pc(pc_q), .op(op_sel), .opcode(rom_rdata), .br_target(br_target),
    .ret_addr(ret_addr), .nxt_pc(nxt_pc), .pc_inc(pc_inc),
    .push_req(push_req), .tbl_go(tbl_go)
  );

  pcfs_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
    .clk(clk), .rst_n(rst_n), .capture(step && tbl_go), .addr_in(tbl_addr),
    .rd_phase(state_q == ST_TBL_RD), .rom_rdata(rom_rdata),
    .addr_q(tbl_addr_q), .data_q(tbl_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      state_q <= ST_FETCH;
    end else begin
      case (state_q)
        ST_FETCH: begin
          if (irq_req) begin
            pc_q <= irq_vec;
          end else if (ins_ready) begin
            pc_q <= nxt_pc;
            if (tbl_go) state_q <= ST_TBL_RD;
          end
        end
        ST_TBL_RD:  state_q <= ST_TBL_OUT;
        ST_TBL_OUT: if (tbl_ready) state_q <= ST_FETCH;
        default:    state_q <= ST_FETCH;
      endcase
    end
  end

  assign rom_addr   = (state_q == ST_TBL_RD) ? tbl_addr_q : pc_q;
  assign ins_valid  = in_fetch && !irq_req;
  assign ins_data   = rom_rdata;
  assign ins_addr   = pc_q;
  assign push_valid = in_fetch && (irq_req || (ins_ready && push_req));
  assign push_addr  = irq_req ? pc_q : pc_inc;
  assign tbl_valid  = (state_q == ST_TBL_OUT);

  p_step_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && op_sel == 3'd0) |=> (ins_addr == ADDR_W'($past(ins_addr) + 1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready) |=> ($stable(ins_addr) && !$past(push_valid)));

  p_slot_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && op_sel == 3'd3) |=> (rom_addr[SLOT_SHIFT-1:0] == '0 && int'(rom_addr) < ZP_LIMIT));

  p_tbl_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && op_sel == 3'd5) |=> (!ins_valid && rom_addr == $past(tbl_addr)));

  p_tbl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_valid && !tbl_ready) |=> (tbl_valid && $stable(tbl_data)));

  p_irq_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !tbl_valid && rom_addr == ins_addr && in_fetch) |=> (ins_addr == $past(irq_vec)));

  p_no_push_in_table_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_fetch) |-> !push_valid);

endmodule

// File: tb/test_pcfs_top.sv
`timescale 1ns/1ps
module test_pcfs_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic        ins_valid, push_valid, tbl_valid;
  logic        ins_ready = 1'b0, irq_req = 1'b0, tbl_ready = 1'b0;
  logic [7:0]  ins_data, tbl_data;
  logic [11:0] ins_addr, push_addr;
  logic [2:0]  op_sel = 3'd0;
  logic [11:0] br_target = '0, ret_addr = '0, irq_vec = '0, tbl_addr = '0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
  endfunction

  assign rom_rdata = rom_fn(rom_addr);

  pcfs_top i_pcfs_top (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_data(ins_data),
    .ins_addr(ins_addr), .op_sel(op_sel), .br_target(br_target),
    .ret_addr(ret_addr), .irq_req(irq_req), .irq_vec(irq_vec),
    .tbl_addr(tbl_addr), .push_valid(push_valid), .push_addr(push_addr),
    .tbl_valid(tbl_valid), .tbl_ready(tbl_ready), .tbl_data(tbl_data)
  );

  // reference model state
  int          m_st = 0;
  logic [11:0] m_pc = '0, m_taddr = '0;
  logic [7:0]  m_tdata = '0;
  string       m_tag = "R1";

  task automatic cmp(input string tag, input string what, input logic [11:0] act, input logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    logic exp_iv, exp_pv;
    string irq_tag;
    irq_tag = (m_st == 0) ? "R10" : "R11";
    exp_iv = (m_st == 0) && !irq_req;
    exp_pv = (m_st == 0) && (irq_req || (ins_ready && (op_sel == 3'd2 || op_sel == 3'd3)));
    cmp(m_tag, "rom_addr", rom_addr, (m_st == 1) ? m_taddr : m_pc);
    cmp(irq_req ? irq_tag : "R3", "ins_valid", {11'd0, ins_valid}, {11'd0, exp_iv});
    if (exp_iv) begin
      cmp(m_tag, "ins_addr", ins_addr, m_pc);
      cmp(m_tag, "ins_data", {4'd0, ins_data}, {4'd0, rom_fn(m_pc)});
    end
    cmp(irq_req ? irq_tag : "R5", "push_valid", {11'd0, push_valid}, {11'd0, exp_pv});
    if (exp_pv) begin
      if (irq_req) cmp("R10", "push_addr", push_addr, m_pc);
      else cmp(op_sel == 3'd3 ? "R6" : "R5", "push_addr", push_addr, m_pc + 12'd1);
    end
    cmp("R9", "tbl_valid", {11'd0, tbl_valid}, {11'd0, (m_st == 2)});
    if (m_st == 2) cmp("R8", "tbl_data", {4'd0, tbl_data}, {4'd0, m_tdata});
  endtask

  task automatic model_step();
    case (m_st)
      0: begin
        if (irq_req) begin
          m_pc = irq_vec; m_tag = "R10";
        end else if (ins_ready) begin
          case (op_sel)
            3'd1: begin m_pc = br_target; m_tag = "R4"; end
            3'd2: begin m_pc = br_target; m_tag = "R5"; end
            3'd3: begin m_pc = {3'd0, rom_fn(m_pc)[5:0], 3'd0}; m_tag = "R6"; end
            3'd4: begin m_pc = ret_addr; m_tag = "R7"; end
            3'd5: begin m_taddr = tbl_addr; m_pc = m_pc + 12'd1; m_st = 1; m_tag = "R8"; end
            default: begin m_pc = m_pc + 12'd1; m_tag = "R2"; end
          endcase
        end else m_tag = "R3";
      end
      1: begin m_tdata = rom_fn(m_taddr); m_st = 2; m_tag = "R11"; end
      default: if (tbl_ready) begin m_st = 0; m_tag = "R9"; end
    endcase
  endtask

  task automatic cyc(input logic [2:0] op, input bit rdy, input bit irq,
                     input logic [11:0] tgt, input logic [11:0] vec,
                     input logic [11:0] ret, input logic [11:0] ta, input bit trdy);
    @(negedge clk);
    op_sel = op; ins_ready = rdy; irq_req = irq; br_target = tgt;
    irq_vec = vec; ret_addr = ret; tbl_addr = ta; tbl_ready = trdy;
    #2;
    check_outputs();
    model_step();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1", "rom_addr in reset", rom_addr, 12'h000);
    cmp("R1", "tbl_valid in reset", {11'd0, tbl_valid}, 12'd0);
    cmp("R1", "ins_valid in reset", {11'd0, ins_valid}, 12'd1);
    rst_n = 1'b1;
    // R3 stall, then R2 steps
    cyc(3'd0, 0, 0, 12'h000, 12'h000, 12'h000, 12'h000, 0);
    cyc(3'd0, 1, 0, 12'h000, 12'h000, 12'h000, 12'h000, 0);
    cyc(3'd7, 1, 0, 12'h000, 12'h000, 12'h000, 12'h000, 0);
    // R4 jump to top, R2 wrap
    cyc(3'd1, 1, 0, 12'hFFF, 12'h000, 12'h000, 12'h000, 0);
    cyc(3'd0, 1, 0, 12'h000, 12'h000, 12'h000, 12'h000, 0);
    cyc(3'd0, 1, 0, 12'h000, 12'h000, 12'h000, 12'h000, 0);
    // R5 call, R7 return
    cyc(3'd2, 1, 0, 12'h7A3, 12'h000, 12'h000, 12'h000, 0);
    cyc(3'd4, 1, 0, 12'h000, 12'h000, 12'h002, 12'h000, 0);
    // R6 short call from an address whose byte has low bits 3Fh (rom byte 3Fh at 003h)
    cyc(3'd1, 1, 0, 12'h003, 12'h000, 12'h000, 12'h000, 0);
    cyc(3'd3, 1, 0, 12'h000, 12'h000, 12'h000, 12'h000, 0);
    // R10 interrupt versus call in the same cycle
    cyc(3'd2, 1, 1, 12'h555, 12'h1C0, 12'h000, 12'h000, 0);
    cyc(3'd0, 1, 0, 12'h000, 12'h000, 12'h000, 12'h000, 0);
    // R8/R9/R11 table read with stalls and an interrupt inside
    cyc(3'd5, 1, 0, 12'h000, 12'h000, 12'h000, 12'hABC, 0);
    cyc(3'd0, 1, 1, 12'h000, 12'h222, 12'h000, 12'h123, 0);
    cyc(3'd0, 1, 1, 12'h000, 12'h222, 12'h000, 12'h123, 0);
    cyc(3'd0, 1, 0, 12'h000, 12'h000, 12'h000, 12'h000, 0);
    cyc(3'd0, 1, 0, 12'h000, 12'h000, 12'h000, 12'h000, 1);
    cyc(3'd0, 1, 0, 12'h000, 12'h000, 12'h000, 12'h000, 0);
    // randomized traffic
    for (int i = 0; i < 4000; i++) begin
      cyc(3'($urandom_range(0, 7)), ($urandom_range(0, 3) != 0), ($urandom_range(0, 9) == 0),
          12'($urandom), 12'($urandom), 12'($urandom), 12'($urandom), ($urandom_range(0, 2) != 0));
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule